// File: doc/BRIEF.md
# Command/Response Register Window

This block is a byte-wide slave register window in front of a command engine of the kind found in security coprocessors. A host claims the single locality, streams a command into one data port byte by byte, starts execution with a strobe in the status register, waits for the response flags, and then drains the response from the same data port. An access register holds the locality claim. A status register carries the handshake flags, and a 16-bit burst count beside it tells the host how many bytes it may move next.

A small built-in responder stands in for the processing core. After a fixed delay it produces a response with a 10-byte header. The response keeps the first two command bytes, states its own total length big-endian in bytes 2 to 5, and carries a zero return code in bytes 6 to 9. Every command byte past the header is echoed after the header. Reads have no side effect except on the data port. Read data is combinational from the address and takes effect at the clock edge on which the strobe is sampled.

Top module: `cmdresp_window`

## Requirements
- R1: After reset the access register reads 0x80, the status byte reads 0xC0 (valid and command-ready), and the burst count reads BUF_DEPTH.
- R2: Writing bit 1 of the access register (offset 0x00) grants the locality and bit 5 then reads 1 (0xA0). Writing bit 5 releases it (0x80 again). Bit 7 always reads 1.
- R3: While the locality is not held, reads of the data port (offset 0x24) return 0xFF and writes to it are ignored.
- R4: Bytes written to the data port fill the command buffer. The command length is taken big-endian from command bytes 2 to 5 and clamped to the range 6 to BUF_DEPTH. Status bit 3 (data-expected) is set until that many bytes have arrived and is clear afterwards. Status is 0x88 while bytes are expected and 0x80 once complete. Further bytes are ignored.
- R5: The burst count reads at offsets 0x19 (low byte) and 0x1A (high byte) with no side effect. It is BUF_DEPTH minus the stored byte count while idle or receiving, 0 while executing, and the number of unread response bytes while responding.
- R6: Writing status bit 5 (GO) starts execution only when a command is being received and data-expected is clear. Status then reads 0x00 for exactly RESP_DELAY cycles and then reads 0x90 (valid and data-available). A GO written at any other time is ignored.
- R7: The response length is the stored byte count, or 10 if fewer bytes were stored. Byte i of the response is as follows: for i<2, command byte i; for i=2..5, the length big-endian; for i=6..9, zero; otherwise, command byte i. Each data read returns the next byte. Data-available (bit 4) clears after the last byte, and any further data read returns 0xFF.
- R8: Writing status bit 1 (retry) while responding rewinds the response to its first byte.
- R9: Writing status bit 6 (command-ready) from any state aborts the current command and returns to idle with status 0xC0 and burst BUF_DEPTH. It takes priority over GO in the same write.
- R10: Offsets 0xF00 to 0xF03 read the 32-bit DEV_ID least significant byte first, and 0xF04 reads REV_ID. Unmapped offsets read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the byte at `addr` |
| rd_en | input | 1 | Read strobe; advances the data port when it addresses it |
| addr | input | ADDR_W | Byte offset into the register window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, valid in the same cycle |

## Verification
The bench targets the edges of the length rule. It sends a header shorter than six bytes, one longer than the buffer, and commands followed by surplus bytes. A design that took the length little-endian, missed the clamp, or kept accepting bytes would overflow the buffer, or would never clear data-expected. The bench checks GO sent too early, GO combined with command-ready, and aborts in every state. A wrong priority or a missing guard shows up there as a command running from a partial buffer. The bench counts the exact length of the busy window and reads the burst count in the middle of a response. This catches an off-by-one in the delay counter, and also catches a status read that moves the response pointer. Retry after draining and data-port access without the locality complete the corner cases.

// File: rtl/cmdresp_pkg.sv
package cmdresp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_EXEC = 2'd2,
    ST_RESP = 2'd3
  } seq_state_t;

  // Register window offsets
  localparam int OFS_ACCESS = 'h000;
  localparam int OFS_STATUS = 'h018;
  localparam int OFS_BC_LO  = 'h019;
  localparam int OFS_BC_HI  = 'h01A;
  localparam int OFS_DATA   = 'h024;
  localparam int OFS_ID     = 'hF00;
  localparam int OFS_REV    = 'hF04;

  // Access register bits
  localparam int ACC_REQ    = 1;
  localparam int ACC_ACT    = 5;

  // Status register bits
  localparam int STS_READY  = 6;
  localparam int STS_GO     = 5;
  localparam int STS_RETRY  = 1;

  // Framing
  localparam int HDR_LEN    = 10;
  localparam int LEN_KNOWN  = 6;

endpackage

// File: rtl/cr_locality.sv
module cr_locality (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_acc,
  input  logic req_bit,
  input  logic rel_bit,
  output logic active
);
  logic act_q, act_d, act_en;

  always_comb begin
    act_d  = act_q;
    act_en = wr_acc;
    if (rel_bit)      act_d = 1'b0;
    else if (req_bit) act_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= 1'b0;
    else if (act_en) act_q <= act_d;
  end

  assign active = act_q;
endmodule

// File: rtl/cr_cmd_store.sv
module cr_cmd_store import cmdresp_pkg::*; #(
  parameter int BUF_DEPTH = 64,
  localparam int CW = $clog2(BUF_DEPTH + 1),
  localparam int AW = $clog2(BUF_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          wr_byte,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] rd_idx,
  output logic [7:0]    rd_byte,
  output logic [CW-1:0] count,
  output logic          need_more
);
  logic [7:0]    mem [BUF_DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;
  logic [31:0]   len_q, len_d;
  logic [CW-1:0] len_eff;
  logic          accept, cnt_en, len_en;

  always_comb begin
    len_eff = (len_q > 32'(BUF_DEPTH)) ? CW'(BUF_DEPTH) : len_q[CW-1:0];
    need_more = (cnt_q < CW'(LEN_KNOWN)) || (cnt_q < len_eff);
    accept = wr_byte && need_more;
  end

  always_comb begin
    cnt_d  = cnt_q;
    len_d  = len_q;
    cnt_en = clear || accept;
    len_en = clear || (accept && cnt_q >= CW'(2) && cnt_q < CW'(LEN_KNOWN));
    if (clear) begin
      cnt_d = '0;
      len_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
      len_d = {len_q[23:0], wdata};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (len_en) len_q <= len_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept && !clear) mem[cnt_q[AW-1:0]] <= wdata;
  end

  assign rd_byte = mem[rd_idx];
  assign count   = cnt_q;
endmodule

// File: rtl/cr_sequencer.sv
module cr_sequencer import cmdresp_pkg::*; #(
  parameter int BUF_DEPTH  = 64,
  parameter int RESP_DELAY = 8,
  localparam int CW = $clog2(BUF_DEPTH + 1),
  localparam int DW = $clog2(RESP_DELAY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          go,
  input  logic          retry,
  input  logic          data_wr,
  input  logic          data_rd,
  input  logic          need_more,
  input  logic [CW-1:0] cmd_count,
  output seq_state_t    state,
  output logic [CW-1:0] rd_ptr,
  output logic [CW-1:0] resp_len,
  output logic [15:0]   burst
);
  seq_state_t    st_q, st_d;
  logic [CW-1:0] ptr_q, ptr_d, len_q, len_d;
  logic [DW-1:0] dly_q, dly_d;
  logic          exec_done, ptr_en, len_en, dly_en;

  assign exec_done = (st_q == ST_EXEC) && (dly_q == DW'(RESP_DELAY - 1));

  always_comb begin
    st_d  = st_q;
    ptr_d = ptr_q;
    dly_d = dly_q;
    len_d = (cmd_count < CW'(HDR_LEN)) ? CW'(HDR_LEN) : cmd_count;
    if (abort) begin
      st_d  = ST_IDLE;
      ptr_d = '0;
      dly_d = '0;
    end else begin
      case (st_q)
        ST_IDLE: if (data_wr) st_d = ST_RECV;
        ST_RECV: if (go && !need_more) begin
                   st_d  = ST_EXEC;
                   dly_d = '0;
                 end
        ST_EXEC: if (exec_done) begin
                   st_d  = ST_RESP;
                   ptr_d = '0;
                 end else begin
                   dly_d = dly_q + 1'b1;
                 end
        ST_RESP: if (retry) ptr_d = '0;
                 else if (data_rd && ptr_q < len_q) ptr_d = ptr_q + 1'b1;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  assign ptr_en = abort || exec_done || (st_q == ST_RESP);
  assign len_en = exec_done && !abort;
  assign dly_en = abort || (st_q == ST_RECV) || (st_q == ST_EXEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ptr_q <= '0;
      len_q <= '0;
      dly_q <= '0;
    end else begin
      st_q <= st_d;
      if (ptr_en) ptr_q <= ptr_d;
      if (len_en) len_q <= len_d;
      if (dly_en) dly_q <= dly_d;
    end
  end

  always_comb begin
    case (st_q)
      ST_EXEC: burst = '0;
      ST_RESP: burst = 16'(len_q - ptr_q);
      default: burst = 16'(BUF_DEPTH) - 16'(cmd_count);
    endcase
  end

  assign state    = st_q;
  assign rd_ptr   = ptr_q;
  assign resp_len = len_q;
endmodule

// File: rtl/cmdresp_window.sv
module cmdresp_window import cmdresp_pkg::*; #(
  parameter int          ADDR_W     = 12,
  parameter int          BUF_DEPTH  = 64,
  parameter int          RESP_DELAY = 8,
  parameter logic [31:0] DEV_ID     = 32'h5A3C_0001,
  parameter logic [7:0]  REV_ID     = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int CW = $clog2(BUF_DEPTH + 1);
  localparam int AW = $clog2(BUF_DEPTH);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  // Decode
  logic hit_acc, hit_sts, hit_data;
  assign hit_acc  = (addr == ADDR_W'(OFS_ACCESS));
  assign hit_sts  = (addr == ADDR_W'(OFS_STATUS));
  assign hit_data = (addr == ADDR_W'(OFS_DATA));

  logic          loc_active, need_more, abort, go, retry, data_wr, data_rd;
  logic          store_wr;
  logic [7:0]    cmd_byte, resp_byte, sts_byte;
  logic [CW-1:0] cmd_count, rd_ptr, resp_len;
  logic [15:0]   burst;
  seq_state_t    state;
  logic          avail, expect_more;

  assign abort   = wr_en && hit_sts && wdata[STS_READY];
  assign go      = wr_en && hit_sts && wdata[STS_GO]    && !wdata[STS_READY];
  assign retry   = wr_en && hit_sts && wdata[STS_RETRY] && !wdata[STS_READY];
  assign data_wr = wr_en && hit_data && loc_active;
  assign data_rd = rd_en && hit_data && loc_active;
  assign store_wr = data_wr && (state == ST_IDLE || state == ST_RECV);

  cr_locality u_locality (
    .clk     (clk),
    .rst_n   (rst_q),
    .wr_acc  (wr_en && hit_acc),
    .req_bit (wdata[ACC_REQ]),
    .rel_bit (wdata[ACC_ACT]),
    .active  (loc_active)
  );

  cr_cmd_store #(.BUF_DEPTH(BUF_DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_q),
    .clear     (abort),
    .wr_byte   (store_wr),
    .wdata     (wdata),
    .rd_idx    (rd_ptr[AW-1:0]),
    .rd_byte   (cmd_byte),
    .count     (cmd_count),
    .need_more (need_more)
  );

  cr_sequencer #(.BUF_DEPTH(BUF_DEPTH), .RESP_DELAY(RESP_DELAY)) u_seq (
    .clk       (clk),
    .rst_n     (rst_q),
    .abort     (abort),
    .go        (go),
    .retry     (retry),
    .data_wr   (data_wr),
    .data_rd   (data_rd),
    .need_more (need_more),
    .cmd_count (cmd_count),
    .state     (state),
    .rd_ptr    (rd_ptr),
    .resp_len  (resp_len),
    .burst     (burst)
  );

  // Response byte built from the command buffer and the header rule
  logic [31:0] rlen32;
  assign rlen32 = 32'(resp_len);
  always_comb begin
    case (int'(rd_ptr))
      0, 1:       resp_byte = cmd_byte;
      2:          resp_byte = rlen32[31:24];
      3:          resp_byte = rlen32[23:16];
      4:          resp_byte = rlen32[15:8];
      5:          resp_byte = rlen32[7:0];
      6, 7, 8, 9: resp_byte = 8'h00;
      default:    resp_byte = cmd_byte;
    endcase
  end

  assign avail       = (state == ST_RESP) && (rd_ptr < resp_len);
  assign expect_more = (state == ST_RECV) && need_more;
  assign sts_byte    = {state != ST_EXEC, state == ST_IDLE, 1'b0, avail, expect_more, 3'b000};

  always_comb begin
    case (addr)
      ADDR_W'(OFS_ACCESS): rdata = {1'b1, 1'b0, loc_active, 5'b00000};
      ADDR_W'(OFS_STATUS): rdata = sts_byte;
      ADDR_W'(OFS_BC_LO):  rdata = burst[7:0];
      ADDR_W'(OFS_BC_HI):  rdata = burst[15:8];
      ADDR_W'(OFS_DATA):   rdata = (loc_active && avail) ? resp_byte : 8'hFF;
      ADDR_W'(OFS_ID):     rdata = DEV_ID[7:0];
      ADDR_W'(OFS_ID + 1): rdata = DEV_ID[15:8];
      ADDR_W'(OFS_ID + 2): rdata = DEV_ID[23:16];
      ADDR_W'(OFS_ID + 3): rdata = DEV_ID[31:24];
      ADDR_W'(OFS_REV):    rdata = REV_ID;
      default:             rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/cr_checker.sv
module cr_checker import cmdresp_pkg::*; #(
  parameter int ADDR_W    = 12,
  parameter int BUF_DEPTH = 64,
  localparam int CW = $clog2(BUF_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_q,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic              loc_active,
  input logic [7:0]        sts_byte,
  input logic [15:0]       burst,
  input seq_state_t        state,
  input logic [CW-1:0]     rd_ptr,
  input logic [CW-1:0]     resp_len,
  input logic [CW-1:0]     cmd_count
);
  assert_locked_data_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_en && addr == ADDR_W'(OFS_DATA) && !loc_active) |-> rdata == 8'hFF);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_q)
    cmd_count <= CW'(BUF_DEPTH));

  assert_busy_burst_R5: assert property (@(posedge clk) disable iff (!rst_q)
    state == ST_EXEC |-> burst == 16'd0);

  assert_go_starts_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (state == ST_RECV && wr_en && addr == ADDR_W'(OFS_STATUS) && wdata[STS_GO]
     && !wdata[STS_READY] && !sts_byte[3]) |=> state == ST_EXEC);

  assert_ptr_bound_R7: assert property (@(posedge clk) disable iff (!rst_q)
    state == ST_RESP |-> rd_ptr <= resp_len);

  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && addr == ADDR_W'(OFS_STATUS) && wdata[STS_READY])
    |=> (sts_byte == 8'hC0 && burst == 16'(BUF_DEPTH)));
endmodule

bind cmdresp_window cr_checker #(.ADDR_W(ADDR_W), .BUF_DEPTH(BUF_DEPTH)) u_cr_checker (
  .clk        (clk),
  .rst_q      (rst_q),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .wdata      (wdata),
  .rdata      (rdata),
  .loc_active (loc_active),
  .sts_byte   (sts_byte),
  .burst      (burst),
  .state      (state),
  .rd_ptr     (rd_ptr),
  .resp_len   (resp_len),
  .cmd_count  (cmd_count)
);

// File: tb/test_cmdresp_window.sv
module test_cmdresp_window;
  localparam int DEPTH = 64;
  localparam int DELAY = 8;
  localparam int AW    = 12;
  localparam int A_ACC = 'h000, A_STS = 'h018, A_BLO = 'h019, A_BHI = 'h01A, A_DAT = 'h024;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;

  int  checks = 0, errors = 0;
  bit  done = 1'b0;
  logic [7:0] cmd [256];

  always #2 clk = ~clk;

  cmdresp_window #(.ADDR_W(AW), .BUF_DEPTH(DEPTH), .RESP_DELAY(DELAY),
                   .DEV_ID(32'h5A3C_0001), .REV_ID(8'h02)) i_cmdresp_window (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic bus_rd(input int a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = AW'(a);
    #1 d = rdata;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  function automatic int target_of(input int hdr);
    int t;
    t = (hdr > DEPTH) ? DEPTH : hdr;
    return (t < 6) ? 6 : t;
  endfunction

  function automatic logic [7:0] exp_resp(input int i, input int rl);
    if (i < 2)  return cmd[i];
    if (i < 6)  return 8'(rl >> (8 * (5 - i)));
    if (i < 10) return 8'h00;
    return cmd[i];
  endfunction

  task automatic load_cmd(input int hdr);
    for (int i = 0; i < 256; i++) cmd[i] = 8'($urandom);
    cmd[2] = 8'(hdr >> 24); cmd[3] = 8'(hdr >> 16);
    cmd[4] = 8'(hdr >> 8);  cmd[5] = 8'(hdr);
  endtask

  // Writes nwr bytes, checks data-expected and burst after each (R4, R5)
  task automatic write_cmd(input int hdr, input int nwr);
    logic [7:0] v;
    int target, stored;
    target = target_of(hdr);
    for (int i = 0; i < nwr; i++) begin
      bus_wr(A_DAT, cmd[i]);
      stored = (i + 1 < target) ? i + 1 : target;
      bus_rd(A_STS, v); chk("R4 data-expected status", v, (stored < target) ? 'h88 : 'h80);
      bus_rd(A_BLO, v); chk("R5 burst while receiving", v, DEPTH - stored);
    end
  endtask

  task automatic run_cmd(input int hdr, input int nwr, input bit do_retry);
    logic [7:0] v;
    int rl, polls;
    load_cmd(hdr);
    write_cmd(hdr, nwr);
    rl = target_of(hdr);
    if (rl < 10) rl = 10;
    bus_wr(A_STS, 8'h20);
    polls = 0;
    do begin
      bus_rd(A_STS, v);
      if (v == 8'h00) polls++;
    end while (v == 8'h00 && polls < 1000);
    chk("R6 busy window length", polls, DELAY);
    chk("R6 response ready status", v, 'h90);
    bus_rd(A_BLO, v); chk("R5 burst at response start", v, rl);
    for (int i = 0; i < rl; i++) begin
      if (i == rl / 2) begin
        bus_rd(A_BLO, v); chk("R5 burst mid response", v, rl - i);
        bus_rd(A_BHI, v); chk("R5 burst high byte", v, 0);
      end
      bus_rd(A_DAT, v); chk($sformatf("R7 response byte %0d", i), v, exp_resp(i, rl));
    end
    bus_rd(A_STS, v); chk("R7 data-available cleared", v, 'h80);
    bus_rd(A_DAT, v); chk("R7 read past end", v, 'hFF);
    if (do_retry) begin
      bus_wr(A_STS, 8'h02);
      bus_rd(A_STS, v); chk("R8 retry restores data-available", v, 'h90);
      bus_rd(A_BLO, v); chk("R8 retry restores burst", v, rl);
      bus_rd(A_DAT, v); chk("R8 retry first byte", v, exp_resp(0, rl));
      bus_rd(A_DAT, v); chk("R8 retry second byte", v, exp_resp(1, rl));
    end
    bus_wr(A_STS, 8'h40);
    bus_rd(A_STS, v); chk("R9 abort after response", v, 'hC0);
    bus_rd(A_BLO, v); chk("R9 burst after abort", v, DEPTH);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements) actual running expected finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    bus_rd(A_ACC, v); chk("R1 access after reset", v, 'h80);
    bus_rd(A_STS, v); chk("R1 status after reset", v, 'hC0);
    bus_rd(A_BLO, v); chk("R1 burst low after reset", v, DEPTH);
    bus_rd(A_BHI, v); chk("R1 burst high after reset", v, 0);

    // R3 data port without locality
    bus_rd(A_DAT, v); chk("R3 locked read", v, 'hFF);
    bus_wr(A_DAT, 8'h55);
    bus_rd(A_STS, v); chk("R3 locked write ignored (status)", v, 'hC0);
    bus_rd(A_BLO, v); chk("R3 locked write ignored (burst)", v, DEPTH);

    // R2 claim
    bus_wr(A_ACC, 8'h02);
    bus_rd(A_ACC, v); chk("R2 locality granted", v, 'hA0);

    // R10 identity
    bus_rd('hF00, v); chk("R10 id byte 0", v, 'h01);
    bus_rd('hF01, v); chk("R10 id byte 1", v, 'h00);
    bus_rd('hF02, v); chk("R10 id byte 2", v, 'h3C);
    bus_rd('hF03, v); chk("R10 id byte 3", v, 'h5A);
    bus_rd('hF04, v); chk("R10 revision", v, 'h02);
    bus_rd('h030, v); chk("R10 unmapped", v, 'h00);

    // Random commands with surplus bytes (R4, R7), some with retry (R8)
    for (int n = 0; n < 5; n++) begin
      int hdr;
      hdr = 10 + int'($urandom % (DEPTH - 9));
      run_cmd(hdr, hdr + 2, n[0]);
    end

    // Boundary lengths
    run_cmd(3, 8, 1'b0);          // short header: six bytes, ten-byte response
    run_cmd(10, 10, 1'b1);        // header only
    run_cmd(1000, DEPTH + 3, 1'b0); // clamp to buffer depth
    run_cmd(DEPTH, DEPTH, 1'b0);

    // R6 early GO ignored, then R9 abort while receiving
    load_cmd(20);
    write_cmd(20, 12);
    bus_wr(A_STS, 8'h20);
    bus_rd(A_STS, v); chk("R6 early GO ignored", v, 'h88);
    bus_rd(A_BLO, v); chk("R6 early GO keeps burst", v, DEPTH - 12);
    bus_wr(A_STS, 8'h40);
    bus_rd(A_STS, v); chk("R9 abort while receiving", v, 'hC0);
    bus_rd(A_BLO, v); chk("R9 abort clears buffer", v, DEPTH);

    // R9 command-ready beats GO in the same write
    load_cmd(12);
    write_cmd(12, 12);
    bus_wr(A_STS, 8'h60);
    bus_rd(A_STS, v); chk("R9 ready wins over GO", v, 'hC0);

    // R6 GO from idle ignored
    bus_wr(A_STS, 8'h20);
    bus_rd(A_STS, v); chk("R6 GO in idle ignored", v, 'hC0);

    // R5 busy burst, R9 abort while executing
    load_cmd(16);
    write_cmd(16, 16);
    bus_wr(A_STS, 8'h20);
    bus_rd(A_BLO, v); chk("R5 burst zero while busy", v, 0);
    bus_rd(A_STS, v); chk("R6 status while busy", v, 'h00);
    bus_wr(A_STS, 8'h40);
    bus_rd(A_STS, v); chk("R9 abort while executing", v, 'hC0);
    repeat (DELAY + 2) @(posedge clk);
    bus_rd(A_STS, v); chk("R9 no response after abort", v, 'hC0);

    // R2 release, R3 gating afterwards
    bus_wr(A_ACC, 8'h20);
    bus_rd(A_ACC, v); chk("R2 locality released", v, 'h80);
    bus_wr(A_DAT, 8'hA5);
    bus_rd(A_STS, v); chk("R3 write after release ignored", v, 'hC0);
    bus_rd(A_DAT, v); chk("R3 read after release", v, 'hFF);

    finish_run();
  end
endmodule